// File: doc/BRIEF.md
# Cascadable Period-Match Timer Pair

This block holds two 16-bit up-counters that count ticks and wrap at a software-chosen period. Each counter takes its ticks either from the bus clock or from rising edges on an external pin. The pin first passes through a synchronizer. A power-of-two prescaler thins the ticks before they reach the counter. Each time a counter reaches its period value, it folds back to zero and raises a one-cycle event pulse. It also sets a sticky flag, which software clears. Surrounding logic can use the pulse as an interrupt request, a DMA request or a converter trigger.

A fuse bit in the first timer's control word joins the two counters into one 32-bit counter. In that mode the first timer supplies the low half. The match then compares the full 32-bit count against the two period registers taken together, and the first timer's control fields drive the whole pair.

Software reaches the block through a single-cycle write port and a combinational read port. Through them it sets the control words, periods and counts, clears flags, and reads everything back. A sleep input stops any counter that runs from the bus clock.

Top module: `tick_pair_timer`

## Requirements
- R1: After reset, every register reads zero: control words, counts, periods and flags. Both event pulses are low.
- R2: The register map is: addresses 0/1/2 hold control, count and period of timer A; addresses 3/4/5 hold the same for timer B; address 6 holds the flags (bit 0 for A, bit 1 for B). When a timer runs from the bus clock at prescale 1 with a nonzero period P, its count steps through 0..P-1. Its event pulse is high for one cycle every P cycles, and the count reads 0 in that cycle.
- R3: Control word bit 0 enables the timer and bits 4:2 select the prescale. The codes 0 to 7 give division by 1, 2, 4, 8, 16, 32, 64 and 256. The gap between event pulses is then P times the division.
- R4: The prescaler is cleared while its timer is disabled. After an enable write, the first event pulse comes exactly P times the division cycles after the write.
- R5: A period of 0 uses the full range: the event fires when the count wraps from 0xFFFF to 0.
- R6: Control word bit 1 selects the external pin. After a two-flop synchronizer, each rising edge counts as one tick. Such a timer keeps counting while sleep is asserted.
- R7: A timer clocked from the bus clock holds its count on every cycle in which the sleep input is high.
- R8: Control bit 5 of timer A fuses the pair. The count is then {count B, count A}, the match compares against {period B, period A}, and timer A's enable, source and prescale govern. Only event bit 0 fires, and timer B's pulse and flag stay low.
- R9: A write to a count register loads the value at the next clock edge. The write overrides any increment or wrap in that cycle.
- R10: An event sets its flag, and the flag stays set until a one is written to its bit at address 6. If a clear and a new match land in the same cycle, the flag stays set.
- R11: A disabled timer holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Stops timers clocked from the bus clock |
| ext_pin | input | 2 | External tick pins, bit k for timer k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| evt_pulse | output | 2 | One-cycle match event per timer |
| evt_flag | output | 2 | Sticky match flags |

## Verification
A stuck or mis-sized prescaler count changes the gap between event pulses by the first multiple of the division. The bench sweeps every prescale code, so this shows within one period. A compare that ignores the fused width fires tens of thousands of cycles too early in 32-bit mode: the low half alone matches after 18 ticks, while the full match needs 65554. A wrong flag, sleep or write priority shows in the very cycle of the clash, as a flag that drops, a count that moves, or a loaded value that is off by one.

// File: rtl/tick_pair_pkg.sv
// Shared types and helpers for the period-match timer pair.
// Assumes a control word of six bits; register addresses are fixed here.
package tick_pair_pkg;

    localparam int CTRL_W    = 6;
    localparam int REGS_PER  = 3;
    localparam int ADDR_FLAG = 6;

    // Control word layout, MSB first: fuse, prescale select, external source, enable
    typedef struct packed {
        logic       fuse;
        logic [2:0] psel;
        logic       ext;
        logic       en;
    } tctrl_t;

    // Maps the 3-bit prescale select to a shift amount (1..64, then 256)
    function automatic logic [3:0] prescale_shift(input logic [2:0] sel);
        return (sel == 3'd7) ? 4'd8 : {1'b0, sel};
    endfunction

endpackage

// File: rtl/tp_tick_src.sv
// Produces the raw tick for one timer: bus-clock ticks gated by sleep, or
// synchronized rising edges of an external pin. Assumes SYNC_STAGES >= 2.
module tp_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_pin,
    input  logic sleep_i,
    input  logic pin,
    output logic tick
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], pin};
    end

    // Selects the tick source and applies enable and sleep gating
    always_comb begin
        if (use_pin) tick = run & chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        else         tick = run & ~sleep_i;
    end
endmodule

// File: rtl/tp_prescale.sv
// Divides a tick stream by a power of two chosen by a 3-bit select.
// Assumes PCW is wide enough for the largest division (256 needs 8 bits).
module tp_prescale
    import tick_pair_pkg::*;
#(
    parameter int PCW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick_in,
    input  logic [2:0] psel,
    output logic       tick_out
);
    logic [PCW-1:0] pcnt_q;
    logic [PCW:0]   span;
    logic           last;

    // Finds the terminal count of the selected division
    always_comb begin
        span     = (PCW+1)'(1) << prescale_shift(psel);
        last     = (pcnt_q == PCW'(span - (PCW+1)'(1)));
        tick_out = tick_in & last;
    end

    // Advances the divider on each input tick and clears it while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt_q <= '0;
        else if (tick_in)   pcnt_q <= last ? '0 : pcnt_q + PCW'(1);
    end
endmodule

// File: rtl/tp_counter_pair.sv
// Holds both counters and their period compare. It is either two separate
// CW-bit counters or one 2*CW-bit counter (index 0 low). A count write
// beats the step; in fused mode any count write suspends the whole step.
module tp_counter_pair #(
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fuse,
    input  logic [1:0]         tick,
    input  logic [1:0]         wr_cnt,
    input  logic [CW-1:0]      wr_data,
    input  logic [1:0][CW-1:0] period,
    output logic [1:0][CW-1:0] cnt,
    output logic [1:0]         fire
);
    localparam int WW = 2 * CW;

    logic [1:0][CW-1:0] cnt_nxt;
    logic [WW-1:0]      wide_inc;

    // Computes the next counts and the match strobes for both widths
    always_comb begin
        wide_inc = cnt + WW'(1);
        cnt_nxt  = cnt;
        fire     = '0;
        if (fuse) begin
            if (wr_cnt != 2'b00) begin
                for (int k = 0; k < 2; k++)
                    if (wr_cnt[k]) cnt_nxt[k] = wr_data;
            end else if (tick[0]) begin
                if (wide_inc == period) begin
                    cnt_nxt = '0;
                    fire[0] = 1'b1;
                end else begin
                    cnt_nxt = wide_inc;
                end
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (wr_cnt[k]) begin
                    cnt_nxt[k] = wr_data;
                end else if (tick[k]) begin
                    if (cnt[k] + CW'(1) == period[k]) begin
                        cnt_nxt[k] = '0;
                        fire[k]    = 1'b1;
                    end else begin
                        cnt_nxt[k] = cnt[k] + CW'(1);
                    end
                end
            end
        end
    end

    // Registers the counts
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/tick_pair_timer.sv
// Top of the cascadable timer pair: register file, per-timer tick chains,
// the shared counter pair, event pulses and sticky flags.
// Assumes CW >= CTRL_W and AW wide enough for seven addresses.
module tick_pair_timer
    import tick_pair_pkg::*;
#(
    parameter int CW          = 16,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2,
    parameter int PCW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_i,
    input  logic [1:0]    ext_pin,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    output logic [1:0]    evt_pulse,
    output logic [1:0]    evt_flag
);
    tctrl_t [1:0]       ctrl_q;
    logic [1:0][CW-1:0] period_q;
    logic [1:0][CW-1:0] cnt_q;
    logic [1:0]         wr_cnt;
    logic [1:0]         run;
    logic [1:0]         raw_tick;
    logic [1:0]         div_tick;
    logic [1:0]         fire;
    logic [1:0]         clr;
    logic               fuse_on;

    assign fuse_on = ctrl_q[0].fuse;

    // Decodes count writes and flag clears from the write port
    always_comb begin
        for (int k = 0; k < 2; k++)
            wr_cnt[k] = wr_en && (wr_addr == AW'(REGS_PER * k + 1));
        clr = (wr_en && wr_addr == AW'(ADDR_FLAG)) ? wr_data[1:0] : 2'b00;
    end

    // Timer B's chain idles while the pair is fused
    always_comb begin
        run[0] = ctrl_q[0].en;
        run[1] = ctrl_q[1].en & ~fuse_on;
    end

    // Stores control words and periods written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < 2; k++) begin
                if (wr_addr == AW'(REGS_PER * k))     ctrl_q[k]   <= tctrl_t'(wr_data[CTRL_W-1:0]);
                if (wr_addr == AW'(REGS_PER * k + 2)) period_q[k] <= wr_data;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_chain
        tp_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run[g]),
            .use_pin (ctrl_q[g].ext),
            .sleep_i (sleep_i),
            .pin     (ext_pin[g]),
            .tick    (raw_tick[g])
        );
        tp_prescale #(.PCW(PCW)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[g]),
            .tick_in  (raw_tick[g]),
            .psel     (ctrl_q[g].psel),
            .tick_out (div_tick[g])
        );
    end

    tp_counter_pair #(.CW(CW)) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .fuse    (fuse_on),
        .tick    (div_tick),
        .wr_cnt  (wr_cnt),
        .wr_data (wr_data),
        .period  (period_q),
        .cnt     (cnt_q),
        .fire    (fire)
    );

    // Registers the event pulses and keeps flags until cleared; a match beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= '0;
            evt_flag  <= '0;
        end else begin
            evt_pulse <= fire;
            evt_flag  <= (evt_flag & ~clr) | fire;
        end
    end

    // Returns the addressed register
    always_comb begin
        case (rd_addr)
            AW'(0):         rd_data = CW'(ctrl_q[0]);
            AW'(1):         rd_data = cnt_q[0];
            AW'(2):         rd_data = period_q[0];
            AW'(3):         rd_data = CW'(ctrl_q[1]);
            AW'(4):         rd_data = cnt_q[1];
            AW'(5):         rd_data = period_q[1];
            AW'(ADDR_FLAG): rd_data = CW'(evt_flag);
            default:        rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tick_pair_timer_chk.sv
// Temporal checks on the timer pair, attached to the top by bind.
module tick_pair_timer_chk #(
    parameter int CW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_i,
    input logic               fuse_on,
    input logic               run0,
    input logic               ext0,
    input logic [1:0]         wr_cnt,
    input logic [1:0][CW-1:0] cnt_q,
    input logic [1:0]         evt_pulse,
    input logic [1:0]         evt_flag
);
    // R2: an event pulse comes with the count at zero
    a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[0] |-> cnt_q[0] == '0) and (evt_pulse[1] |-> cnt_q[1] == '0));

    // R7: sleep freezes a bus-clocked timer A
    a_r7_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep_i) && !$past(ext0) && !$past(wr_cnt[0])) |-> $stable(cnt_q[0]));

    // R8: timer B stays silent while fused
    a_r8_high_half_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fuse_on) |-> !evt_pulse[1]);

    // R10: a pulse always leaves its flag set
    a_r10_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse & ~evt_flag) == 2'b00);

    // R11: a disabled timer A keeps its count
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run0) && !$past(wr_cnt[0])) |-> $stable(cnt_q[0]));
endmodule

bind tick_pair_timer tick_pair_timer_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .fuse_on   (fuse_on),
    .run0      (run[0]),
    .ext0      (ctrl_q[0].ext),
    .wr_cnt    (wr_cnt),
    .cnt_q     (cnt_q),
    .evt_pulse (evt_pulse),
    .evt_flag  (evt_flag)
);

// File: tb/tick_pair_timer_tb.sv
module tick_pair_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic [1:0]  ext_pin = 2'b00;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  evt_pulse;
    logic [1:0]  evt_flag;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic seen_hi = 1'b0;

    tick_pair_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_pulse(evt_pulse), .evt_flag(evt_flag)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 3'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_pulse(input int idx, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (evt_pulse[1]) seen_hi = 1'b1;
        end while (!evt_pulse[idx] && n < limit);
    endtask

    initial begin
        int v, a, n1, n2, dv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int r = 0; r < 7; r++) begin
            rd(r, v);
            check(v == 0, "R1 reg", v, 0);
        end
        check(evt_pulse == 2'b00, "R1 pulse", int'(evt_pulse), 0);
        check(evt_flag == 2'b00, "R1 flag", int'(evt_flag), 0);

        // R3/R4: sweep every prescale code with period 3
        for (int s = 0; s < 8; s++) begin
            dv = (s == 7) ? 256 : (1 << s);
            wr(0, 0);
            wr(1, 0);
            wr(2, 3);
            wr(0, 1 | (s << 2));
            wait_pulse(0, 2000, n1);
            check(n1 == 3 * dv, "R4 first gap", n1, 3 * dv);
            wait_pulse(0, 2000, n2);
            check(n2 == 3 * dv, "R3 gap", n2, 3 * dv);
            if (s == 3) begin
                wr(0, 0);
                repeat (5) @(negedge clk);
            end
        end

        // R2: period 400 at prescale 1
        wr(0, 0); wr(1, 0); wr(2, 400); wr(0, 1);
        wait_pulse(0, 1000, n1);
        check(n1 == 400, "R2 gap", n1, 400);
        rd(1, v);
        check(v == 0, "R2 zero at pulse", v, 0);
        repeat (150) @(negedge clk);
        rd(1, v);
        check(v == 150, "R2 count", v, 150);

        // R9: write beats increment
        wr(1, 100);
        rd(1, v);
        check(v == 100, "R9 load", v, 100);

        // R7: sleep freezes bus-clocked timer
        sleep_i = 1'b1;
        rd(1, a);
        repeat (10) @(negedge clk);
        rd(1, v);
        check(v == a, "R7 frozen", v, a);
        sleep_i = 1'b0;
        repeat (4) @(negedge clk);
        rd(1, v);
        check(v == a + 4, "R7 resumes", v, a + 4);

        // R11: disabled timer holds
        wr(0, 0);
        rd(1, a);
        repeat (10) @(negedge clk);
        rd(1, v);
        check(v == a, "R11 hold", v, a);

        // R5: period 0 wraps at full range
        wr(1, 16'hFFFC); wr(2, 0); wr(0, 1);
        wait_pulse(0, 100, n1);
        check(n1 == 4, "R5 wrap", n1, 4);

        // R10: flag sticky, match beats clear
        wr(0, 0); wr(1, 0); wr(2, 3); wr(0, 1);
        wait_pulse(0, 100, n1);
        @(negedge clk);
        wr(6, 1);
        check(evt_pulse[0] == 1'b1, "R10 pulse with clear", int'(evt_pulse[0]), 1);
        check(evt_flag[0] == 1'b1, "R10 match wins", int'(evt_flag[0]), 1);
        wr(6, 1);
        check(evt_flag[0] == 1'b0, "R10 cleared", int'(evt_flag[0]), 0);
        wr(0, 0);

        // R6: external pin edges, sleep asserted
        wr(4, 0); wr(5, 0); wr(3, 3);
        sleep_i = 1'b1;
        for (int e = 0; e < 5; e++) begin
            @(negedge clk); ext_pin[1] = 1'b1;
            repeat (3) @(negedge clk);
            ext_pin[1] = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(4, v);
        check(v == 5, "R6 edges", v, 5);
        sleep_i = 1'b0;
        wr(3, 0);

        // R8: fused 32-bit match at 0x20002 from 0x0000FFF0
        wr(6, 3);
        wr(1, 16'hFFF0); wr(4, 0); wr(2, 2); wr(5, 2);
        seen_hi = 1'b0;
        wr(0, 16'h21);
        wait_pulse(0, 70000, n1);
        check(n1 == 65554, "R8 fused gap", n1, 65554);
        rd(1, v);
        check(v == 0, "R8 low zero", v, 0);
        rd(4, v);
        check(v == 0, "R8 high zero", v, 0);
        check(!seen_hi && evt_flag[1] == 1'b0, "R8 high silent", int'(seen_hi), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule